// File: doc/BRIEF.md
# Temperature-Aware Refresh Interval Generator

This block paces the periodic refresh requests of one DRAM rank. It emits a one-cycle request pulse at a fixed spacing, and that spacing follows the device temperature. A temperature sensor delivers signed whole-degree samples, each marked by a valid strobe. Every sample is sorted into one of four rate modes: relaxed, normal (1x), doubled (2x) or quadrupled (4x). The active mode sets how many controller clock cycles separate two requests. A command scheduler downstream turns each pulse into a refresh command.

The block changes mode with built-in hysteresis. A move to a faster rate takes effect straight away. A move to a slower rate waits for a cooler reading and then for the interval already running to finish. The relaxed rate is only allowed while software enables it. The block also guards against a silent sensor. If no sample arrives within a programmable number of cycles, it falls back to the doubled rate. It leaves reset in the doubled rate as well.

Top module: `refresh_rate_sel`

## Requirements
- R1: During and right after reset the active mode is 2x (code 2) and no request is asserted. The first request is asserted after the N(2x)−1-th rising clock edge with reset low.
- R2: N(m) is the number of clock cycles per request in mode m. With a retention window of 128, 64, 32 or 16 ms for codes 0, 1, 2 and 3, N(m) = floor(floor(floor(window_ps / CMDS) / CLK_PS) / SIM_DIV), with a minimum of 2. CMDS defaults to 8192. Requests in a steady mode are exactly N(m) cycles apart, and no two requests are ever closer than N(4x) or further apart than N(relaxed).
- R3: A sample t (signed, °C) maps to a mode code: t ≥ 85 gives 4x (3), 55..84 gives 2x (2), 26..54 gives 1x (1), and t ≤ 25 gives relaxed (0).
- R4: Relaxed mode is used only while relax_en is high. With relax_en low, a reading of 25 °C or less gives 1x. If relax_en drops while relaxed mode is active, the mode becomes 1x on the next clock edge.
- R5: A sample leads to a slower mode only when t+3 falls in that slower band. The thresholds are therefore 81 °C to leave 4x, 51 °C to leave 2x and 22 °C to reach relaxed. Readings between such a threshold and the band edge keep the current mode.
- R6: A sample that calls for a faster mode changes the reported mode on the next clock edge. The next request comes no later than N(new mode) cycles after that sample.
- R7: A slower mode is adopted only on the clock edge that ends the running interval, that is, the edge after a request cycle. The mode reported before that edge stays unchanged.
- R8: With tmo_limit nonzero, once more than tmo_limit cycles have passed with no valid sample, a mode slower than 2x is raised to 2x at once. With tmo_limit zero no fallback happens.
- R9: ref_req is high for a single cycle at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| temp_valid | input | 1 | Marks a new temperature sample |
| temp_c | input | TEMP_W | Signed temperature sample in °C |
| relax_en | input | 1 | Software enable for the relaxed mode |
| tmo_limit | input | TMO_W | Sample timeout in cycles; 0 disables it |
| ref_req | output | 1 | One-cycle refresh request pulse |
| mode | output | 2 | Active mode: 0 relaxed, 1 1x, 2 2x, 3 4x |

## Verification
The bench builds the block with CLK_PS = 8000 and SIM_DIV = 16. This shrinks the intervals to 122, 61, 30 and 15 cycles. Every mode and every pending slower change at an interval boundary can then be reached within a few thousand cycles. The timeout limit is driven to 50 cycles, which makes the fallback to 2x observable and lets the bench compare it with a disabled timeout in the same run.

// File: rtl/refsel_pkg.sv
package refsel_pkg;

    typedef enum logic [1:0] {
        RATE_RELAX = 2'd0,
        RATE_1X    = 2'd1,
        RATE_2X    = 2'd2,
        RATE_4X    = 2'd3
    } rate_t;

    // lowest temperature of each band, degrees C
    localparam int HOT_C  = 85;
    localparam int WARM_C = 55;
    localparam int MILD_C = 26;
    localparam int HYST_C = 3;

    typedef struct packed {
        rate_t next;     // target rate after this cycle
        logic  faster;   // target is faster than the active rate
    } decision_t;

    function automatic int unsigned window_ms(rate_t r);
        case (r)
            RATE_RELAX: return 128;
            RATE_1X:    return 64;
            RATE_2X:    return 32;
            default:    return 16;
        endcase
    endfunction

    function automatic int unsigned interval_cycles(rate_t r, int unsigned clk_ps,
                                                    int unsigned cmds, int unsigned div);
        longint unsigned win_ps;
        longint unsigned cyc;
        win_ps = longint'(window_ms(r)) * 64'd1000000000;
        cyc    = ((win_ps / longint'(cmds)) / longint'(clk_ps)) / longint'(div);
        if (cyc < 2) cyc = 2;
        return int'(cyc);
    endfunction

    function automatic rate_t classify(int t, logic relax_ok);
        if (t >= HOT_C)       return RATE_4X;
        else if (t >= WARM_C) return RATE_2X;
        else if (t >= MILD_C) return RATE_1X;
        else if (relax_ok)    return RATE_RELAX;
        else                  return RATE_1X;
    endfunction

endpackage

// File: rtl/refsel_decide.sv
module refsel_decide
    import refsel_pkg::*;
#(
    parameter int TEMP_W = 8
) (
    input  logic                     temp_valid,
    input  logic signed [TEMP_W-1:0] temp_c,
    input  logic                     relax_en,
    input  logic                     stale,
    input  rate_t                    tgt,
    input  rate_t                    active,
    output decision_t                dec
);
    int    tc;
    rate_t raw;
    rate_t cool;
    rate_t nxt;

    always_comb begin
        tc   = int'(temp_c);
        raw  = classify(tc, relax_en);
        cool = classify(tc + HYST_C, relax_en);
        nxt  = tgt;
        if (temp_valid) begin
            if (raw > tgt)       nxt = raw;
            else if (cool < tgt) nxt = cool;
        end else if (stale && (tgt < RATE_2X)) begin
            nxt = RATE_2X;
        end
        if (!relax_en && (nxt == RATE_RELAX)) nxt = RATE_1X;
        dec.next   = nxt;
        dec.faster = (nxt > active);
    end
endmodule

// File: rtl/refsel_staleness.sv
module refsel_staleness #(
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             temp_valid,
    input  logic [TMO_W-1:0] tmo_limit,
    output logic             stale
);
    logic [TMO_W-1:0] quiet;

    always_ff @(posedge clk) begin
        if (rst)                    quiet <= '0;
        else if (temp_valid)        quiet <= '0;
        else if (quiet < tmo_limit) quiet <= quiet + TMO_W'(1);
    end

    assign stale = (tmo_limit != '0) && (quiet >= tmo_limit);
endmodule

// File: rtl/refsel_pacer.sv
module refsel_pacer
    import refsel_pkg::*;
#(
    parameter int unsigned CLK_PS  = 8000,
    parameter int unsigned CMDS    = 8192,
    parameter int unsigned SIM_DIV = 1
) (
    input  logic      clk,
    input  logic      rst,
    input  decision_t dec,
    output logic      req,
    output rate_t     active,
    output rate_t     tgt
);
    localparam int unsigned N_MAX = interval_cycles(RATE_RELAX, CLK_PS, CMDS, SIM_DIV);
    localparam int          CNT_W = $clog2(N_MAX);

    logic [CNT_W-1:0] reload_tab [4];
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cnt_dec;
    logic [CNT_W-1:0] new_top;

    for (genvar g = 0; g < 4; g++) begin : g_tab
        assign reload_tab[g] = CNT_W'(interval_cycles(rate_t'(g), CLK_PS, CMDS, SIM_DIV) - 1);
    end

    assign req     = (cnt == '0);
    assign cnt_dec = cnt - CNT_W'(1);
    assign new_top = reload_tab[dec.next];

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= reload_tab[RATE_2X];
            active <= RATE_2X;
            tgt    <= RATE_2X;
        end else begin
            tgt <= dec.next;
            if (req) begin
                active <= dec.next;
                cnt    <= new_top;
            end else if (dec.faster) begin
                active <= dec.next;
                cnt    <= (cnt_dec > new_top) ? new_top : cnt_dec;
            end else begin
                cnt <= cnt_dec;
            end
        end
    end
endmodule

// File: rtl/refresh_rate_sel.sv
module refresh_rate_sel
    import refsel_pkg::*;
#(
    parameter int unsigned CLK_PS  = 8000,
    parameter int unsigned CMDS    = 8192,
    parameter int unsigned SIM_DIV = 1,
    parameter int          TEMP_W  = 8,
    parameter int          TMO_W   = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     temp_valid,
    input  logic signed [TEMP_W-1:0] temp_c,
    input  logic                     relax_en,
    input  logic [TMO_W-1:0]         tmo_limit,
    output logic                     ref_req,
    output logic [1:0]               mode
);
    decision_t dec;
    rate_t     active;
    rate_t     tgt;
    logic      stale;

    refsel_staleness #(.TMO_W(TMO_W)) u_stale (
        .clk(clk), .rst(rst), .temp_valid(temp_valid),
        .tmo_limit(tmo_limit), .stale(stale)
    );

    refsel_decide #(.TEMP_W(TEMP_W)) u_decide (
        .temp_valid(temp_valid), .temp_c(temp_c), .relax_en(relax_en),
        .stale(stale), .tgt(tgt), .active(active), .dec(dec)
    );

    refsel_pacer #(.CLK_PS(CLK_PS), .CMDS(CMDS), .SIM_DIV(SIM_DIV)) u_pacer (
        .clk(clk), .rst(rst), .dec(dec),
        .req(ref_req), .active(active), .tgt(tgt)
    );

    assign mode = active;
endmodule

// File: rtl/refsel_checker.sv
module refsel_checker
    import refsel_pkg::*;
#(
    parameter int unsigned CLK_PS  = 8000,
    parameter int unsigned CMDS    = 8192,
    parameter int unsigned SIM_DIV = 1,
    parameter int          TEMP_W  = 8
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     temp_valid,
    input logic signed [TEMP_W-1:0] temp_c,
    input logic                     relax_en,
    input logic                     ref_req,
    input logic [1:0]               mode
);
    localparam int unsigned N_FAST = interval_cycles(RATE_4X, CLK_PS, CMDS, SIM_DIV);
    localparam int unsigned N_SLOW = interval_cycles(RATE_RELAX, CLK_PS, CMDS, SIM_DIV);

    logic [15:0] since;
    logic        seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            since <= '0;
            seen  <= 1'b0;
        end else if (ref_req) begin
            since <= 16'd1;
            seen  <= 1'b1;
        end else if (since != 16'hFFFF) begin
            since <= since + 16'd1;
        end
    end

    AST_RESET_MODE: assert property (@(posedge clk)
        $fell(rst) |-> (mode == 2'd2 && !ref_req)); // R1

    AST_GAP_FLOOR: assert property (@(posedge clk) disable iff (rst)
        (ref_req && seen) |-> (32'(since) >= N_FAST)); // R2

    AST_GAP_CEIL: assert property (@(posedge clk) disable iff (rst)
        (ref_req && seen) |-> (32'(since) <= N_SLOW)); // R2

    AST_HOT_SAMPLE: assert property (@(posedge clk) disable iff (rst)
        (temp_valid && (temp_c >= 85)) |=> (mode == 2'd3)); // R3

    AST_RELAX_GATED: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'd0) |-> $past(relax_en)); // R4

    AST_SLOWDOWN_AT_END: assert property (@(posedge clk) disable iff (rst)
        !ref_req |=> (mode >= $past(mode))); // R7

    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
        ref_req |=> !ref_req); // R9
endmodule

bind refresh_rate_sel refsel_checker #(
    .CLK_PS(CLK_PS), .CMDS(CMDS), .SIM_DIV(SIM_DIV), .TEMP_W(TEMP_W)
) u_chk (
    .clk(clk), .rst(rst), .temp_valid(temp_valid), .temp_c(temp_c),
    .relax_en(relax_en), .ref_req(ref_req), .mode(mode)
);

// File: tb/sim_refresh_rate_sel.sv
`timescale 1ns/1ps
module sim_refresh_rate_sel;
    localparam int CLK_PS = 8000;
    localparam int DIV    = 16;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              temp_valid = 1'b0;
    logic signed [7:0] temp_c = '0;
    logic              relax_en = 1'b0;
    logic [15:0]       tmo_limit = '0;
    logic              ref_req;
    logic [1:0]        mode;

    int n_chk = 0;
    int n_err = 0;

    always #4 clk = ~clk;

    refresh_rate_sel #(.CLK_PS(CLK_PS), .SIM_DIV(DIV)) u0 (
        .clk(clk), .rst(rst), .temp_valid(temp_valid), .temp_c(temp_c),
        .relax_en(relax_en), .tmo_limit(tmo_limit), .ref_req(ref_req), .mode(mode)
    );

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    function automatic int n_of(int m);
        longint ps;
        ps = longint'(128 >> m) * 1000000000;
        ps = ps / 8192;
        ps = ps / CLK_PS;
        ps = ps / DIV;
        return (ps < 2) ? 2 : int'(ps);
    endfunction

    function automatic int band_of(int t, bit ren);
        if (t >= 85) return 3;
        if (t >= 55) return 2;
        if (t > 25)  return 1;
        return ren ? 0 : 1;
    endfunction

    function automatic int floor_of(int m);
        case (m)
            3: return 85;
            2: return 55;
            default: return 26;
        endcase
    endfunction

    function automatic int mdl_next(int cur, int t, bit ren);
        int m;
        if (band_of(t, ren) > cur) return band_of(t, ren);
        m = cur;
        while (m > 0 && (t + 3) < floor_of(m) && !(m == 1 && !ren)) m--;
        return m;
    endfunction

    int m_mode, m_tgt, m_left, m_quiet;

    always @(posedge clk) begin
        int nt;
        if (rst) begin
            m_mode = 2; m_tgt = 2; m_left = n_of(2) - 1; m_quiet = 0;
        end else begin
            nt = m_tgt;
            if (temp_valid) nt = mdl_next(m_tgt, int'(temp_c), relax_en);
            else if (tmo_limit != 0 && m_quiet >= int'(tmo_limit) && nt < 2) nt = 2;
            if (!relax_en && nt == 0) nt = 1;
            if (temp_valid) m_quiet = 0;
            else if (m_quiet < int'(tmo_limit)) m_quiet++;
            if (m_left == 0) begin
                m_mode = nt;
                m_left = n_of(nt) - 1;
            end else begin
                m_left--;
                if (nt > m_mode) begin
                    m_mode = nt;
                    if (m_left > n_of(nt) - 1) m_left = n_of(nt) - 1;
                end
            end
            m_tgt = nt;
        end
    end

    // per-cycle comparison and pulse monitor
    int cyc = 0, last_pulse = -1, last_gap = 0, doubles = 0;
    logic prev_req = 1'b0;

    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            chk("R2 request timing vs model", int'(ref_req), int'(m_left == 0));
            chk("R3 mode vs model", int'(mode), m_mode);
            if (ref_req) begin
                if (last_pulse >= 0) last_gap = cyc - last_pulse;
                last_pulse = cyc;
            end
            if (ref_req && prev_req) doubles++;
            prev_req = ref_req;
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic step(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            #1;
        end
    endtask

    task automatic wait_pulse();
        do step(1); while (!ref_req);
    endtask

    task automatic sample(int t);
        @(negedge clk);
        #1;
        temp_valid = 1'b1;
        temp_c = 8'(t);
        step(1);
        temp_valid = 1'b0;
    endtask

    bit done = 0;

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        int k;
        step(5);
        chk("R1 reset mode", int'(mode), 2);
        chk("R1 reset no request", int'(ref_req), 0);
        rst = 1'b0;
        #1;
        k = 0;
        while (!ref_req) begin step(1); k++; end
        chk("R1 first request edge count", k, n_of(2) - 1);
        wait_pulse();
        chk("R2 2x spacing", last_gap, 30);

        sample(40);
        chk("R7 slower held until interval end", int'(mode), 2);
        wait_pulse(); step(1);
        chk("R7 slower adopted at interval end", int'(mode), 1);
        wait_pulse();
        chk("R2 1x spacing", last_gap, 61);

        sample(90);
        chk("R3 hot sample gives 4x", int'(mode), 3);
        k = 0;
        while (!ref_req) begin step(1); k++; end
        chk("R6 request within new interval", int'(k <= 14), 1);
        wait_pulse();
        chk("R2 4x spacing", last_gap, 15);

        sample(83);
        step(20);
        chk("R5 82-84 keeps 4x", int'(mode), 3);
        sample(81);
        wait_pulse(); step(1);
        chk("R5 81 leaves 4x for 2x", int'(mode), 2);
        sample(53);
        step(35);
        chk("R5 53 keeps 2x", int'(mode), 2);

        sample(10);
        wait_pulse(); step(1);
        chk("R4 cold without enable gives 1x", int'(mode), 1);
        relax_en = 1'b1;
        sample(10);
        wait_pulse(); step(1);
        chk("R4 cold with enable gives relaxed", int'(mode), 0);
        wait_pulse();
        chk("R2 relaxed spacing", last_gap, 122);
        relax_en = 1'b0;
        step(1);
        chk("R4 enable drop leaves relaxed", int'(mode), 1);

        sample(60);
        chk("R3 warm sample gives 2x", int'(mode), 2);

        tmo_limit = 16'd50;
        sample(30);
        wait_pulse(); step(1);
        chk("R8 1x before timeout", int'(mode), 1);
        step(80);
        chk("R8 timeout falls back to 2x", int'(mode), 2);
        tmo_limit = 16'd0;
        sample(30);
        wait_pulse(); step(1);
        step(120);
        chk("R8 zero limit disables fallback", int'(mode), 1);

        sample(-40);
        chk("R3 negative sample without enable stays 1x", int'(mode), 1);

        chk("R9 no back-to-back requests", doubles, 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule